// File: doc/BRIEF.md
# Activity/Inactivity Rate Controller

This block watches a stream of filtered three-axis acceleration samples and decides whether the device has gone still. When every axis has stayed within a programmable magnitude band for a programmable number of 512-sample blocks, the block declares the device inactive. It raises a status bit and, if routing is enabled, an interrupt. It also forces the effective sample-rate code down to the 12.5 Hz code. The rate setting held by the user is never rewritten. Only the rate presented to the sampler changes.

A single over-threshold sample on any axis ends the inactive state at the next clock edge. That edge also hands the user's rate code back to the sampler. The feature works only while the nominal rate is at or below the 833 Hz code. At faster rates, or while the enable is low, the block stays active and holds its counter at zero.

The rate code encoding used throughout is: 0 off, 1 = 12.5 Hz, 2 = 26 Hz, 3 = 52 Hz, 4 = 104 Hz, 5 = 208 Hz, 6 = 416 Hz, 7 = 833 Hz, 8 and above are faster rates.

Top module: `act_inact_ctrl`

## Requirements
- R1: A sample counts as over-threshold when |a| > thr × 2^(DATA_W-7) on at least one axis, for positive and negative samples alike (thr is the 6-bit threshold, so one LSB is full scale / 64). A magnitude equal to the limit counts as quiet. -32768 has magnitude 32768.
- R2: With the feature enabled and the rate allowed, sleep_state rises on the clock edge that captures the N-th consecutive valid quiet sample, where N = 512 × sleep_dur.
- R3: sleep_dur = 0 is treated as one block (N = 512).
- R4: While sleep_state is 1, eff_rate is 1 (12.5 Hz) and rate_override is 1. Otherwise eff_rate equals rate_code and rate_override is 0.
- R5: A valid over-threshold sample taken while inactive clears sleep_state on the edge that captures it, and eff_rate returns to rate_code.
- R6: When rate_code > 7 (faster than 833 Hz), the block stays active and its counter is held at zero.
- R7: A valid over-threshold sample restarts the quiet count from zero. A full N further quiet samples are then needed.
- R8: When feat_en is 0, the block is forced active and the count is cleared on the same edge. After re-enabling, a full N quiet samples are needed.
- R9: sleep_irq equals sleep_state when irq_route is 1, and is 0 when irq_route is 0.
- R10: Samples presented with sample_valid = 0 neither advance the count nor wake the block.
- R11: After reset, sleep_state = 0, rate_override = 0 and eff_rate = rate_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Qualifies the three axis samples |
| accel_x | input | DATA_W | X-axis filtered sample, two's complement |
| accel_y | input | DATA_W | Y-axis filtered sample, two's complement |
| accel_z | input | DATA_W | Z-axis filtered sample, two's complement |
| thr | input | THR_W | Unsigned magnitude threshold, LSB = full scale / 64 |
| sleep_dur | input | DUR_W | Duration in 512-sample blocks, 0 means 1 |
| feat_en | input | 1 | Enables the feature |
| irq_route | input | 1 | Routes sleep_state to sleep_irq |
| rate_code | input | RATE_W | User's nominal rate setting |
| sleep_state | output | 1 | 1 while inactive |
| sleep_irq | output | 1 | Routed sleep status |
| rate_override | output | 1 | 1 while the low rate is being forced |
| eff_rate | output | RATE_W | Rate code presented to the sampler |

## Verification
The hardest state to reach from the ports is a long quiet run that is cut short just before it completes, where the count must restart rather than resume. The first case cuts the run with an over-threshold sample. The second cuts it by toggling the enable. The bench drives exactly 1023 or 511 quiet samples after the interruption and checks that the block is still active. One more sample must then tip it into sleep. Threshold edge cases use a vector table: each vector first puts the block to sleep with 512 zero samples, then applies a single probe sample. Whether the block wakes shows how the comparator classified that sample.

// File: rtl/ai_pkg.sv
// Shared types and defaults for the activity/inactivity rate controller.
// Assumes rate codes grow monotonically with sample rate.
package ai_pkg;
    typedef enum logic {ST_ACTIVE = 1'b0, ST_INACTIVE = 1'b1} ai_state_e;

    localparam int AI_RATE_W     = 4;
    localparam int AI_LOW_CODE   = 1;   // 12.5 Hz
    localparam int AI_MAX_OK     = 7;   // 833 Hz
    localparam int AI_BLOCK_LOG2 = 9;   // 512 samples per duration LSB
endpackage

// File: rtl/ai_axis_cmp.sv
// Compares the magnitude of one signed axis sample against the scaled
// threshold. Assumes DATA_W - 1 >= THR_W so the threshold spans full scale.
module ai_axis_cmp #(
    parameter int DATA_W = 16,
    parameter int THR_W  = 6
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [THR_W-1:0]  thr,
    output logic              over
);
    localparam int SHIFT = DATA_W - 1 - THR_W;

    logic signed [DATA_W:0] wide;
    logic        [DATA_W:0] mag;
    logic        [DATA_W:0] lim;

    // Magnitude of the sample, one bit wider so the most negative value fits.
    always_comb begin
        wide = {sample[DATA_W-1], sample};
        mag  = wide[DATA_W] ? unsigned'(-wide) : unsigned'(wide);
        lim  = (DATA_W+1)'(thr) << SHIFT;
        over = (mag > lim);
    end
endmodule

// File: rtl/ai_quiet_detect.sv
// Runs one comparator per axis and reports whether any axis is over
// the threshold. Assumes axes are packed lowest index first.
module ai_quiet_detect #(
    parameter int DATA_W = 16,
    parameter int THR_W  = 6,
    parameter int AXES   = 3
) (
    input  logic [AXES*DATA_W-1:0] samples,
    input  logic [THR_W-1:0]       thr,
    output logic                   any_over
);
    logic [AXES-1:0] axis_over;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        ai_axis_cmp #(.DATA_W(DATA_W), .THR_W(THR_W)) u_cmp (
            .sample (samples[g*DATA_W +: DATA_W]),
            .thr    (thr),
            .over   (axis_over[g])
        );
    end

    // Any single axis over the limit makes the sample active.
    always_comb any_over = |axis_over;
endmodule

// File: rtl/ai_sleep_fsm.sv
// Counts consecutive quiet samples and holds the active/inactive state.
// Assumes sample_valid marks one sample per high cycle.
module ai_sleep_fsm #(
    parameter int DUR_W      = 4,
    parameter int BLOCK_LOG2 = ai_pkg::AI_BLOCK_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_en,
    input  logic             rate_ok,
    input  logic             sample_valid,
    input  logic             any_over,
    input  logic [DUR_W-1:0] sleep_dur,
    output logic             sleep
);
    import ai_pkg::*;
    localparam int CNT_W = DUR_W + BLOCK_LOG2;

    ai_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;
    logic [CNT_W:0]   next_cnt;

    // Required quiet-sample count; a zero duration means one block.
    always_comb begin
        target   = CNT_W'((sleep_dur == '0) ? DUR_W'(1) : sleep_dur) << BLOCK_LOG2;
        next_cnt = {1'b0, cnt} + 1'b1;
    end

    // State and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
        end else if (!feat_en || !rate_ok) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
        end else if (sample_valid) begin
            if (any_over) begin
                state <= ST_ACTIVE;
                cnt   <= '0;
            end else if (state == ST_ACTIVE) begin
                if (next_cnt >= {1'b0, target}) begin
                    state <= ST_INACTIVE;
                    cnt   <= '0;
                end else begin
                    cnt <= next_cnt[CNT_W-1:0];
                end
            end
        end
    end

    always_comb sleep = (state == ST_INACTIVE);

    AST_WAKE_ON_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && any_over) |=> !sleep); // R5
    AST_RESTART_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && any_over) |=> (cnt == '0)); // R7
    AST_DISABLE_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_en |=> (!sleep && cnt == '0)); // R8
    AST_RATE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_ok |=> !sleep); // R6
    AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> $past(sample_valid && !any_over)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && feat_en && rate_ok) |=> ($stable(cnt) && $stable(state))); // R10
endmodule

// File: rtl/ai_rate_mux.sv
// Chooses the rate code seen by the sampler and gates the interrupt.
// Assumes the low-rate code is a constant of the sampler's encoding.
module ai_rate_mux #(
    parameter int RATE_W   = ai_pkg::AI_RATE_W,
    parameter int LOW_CODE = ai_pkg::AI_LOW_CODE
) (
    input  logic              sleep,
    input  logic              irq_route,
    input  logic [RATE_W-1:0] rate_code,
    output logic [RATE_W-1:0] eff_rate,
    output logic              rate_override,
    output logic              sleep_irq
);
    // Override the presented rate while inactive; the stored code is untouched.
    always_comb begin
        eff_rate      = sleep ? RATE_W'(LOW_CODE) : rate_code;
        rate_override = sleep;
        sleep_irq     = sleep & irq_route;
    end
endmodule

// File: rtl/act_inact_ctrl.sv
// Top of the activity/inactivity rate controller. Detects long quiet
// periods on three axes and forces a low sample rate until motion returns.
// Assumes samples are already filtered and arrive one per valid cycle.
module act_inact_ctrl #(
    parameter int DATA_W     = 16,
    parameter int THR_W      = 6,
    parameter int DUR_W      = 4,
    parameter int RATE_W     = ai_pkg::AI_RATE_W,
    parameter int BLOCK_LOG2 = ai_pkg::AI_BLOCK_LOG2,
    parameter int MAX_OK     = ai_pkg::AI_MAX_OK,
    parameter int LOW_CODE   = ai_pkg::AI_LOW_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] accel_x,
    input  logic [DATA_W-1:0] accel_y,
    input  logic [DATA_W-1:0] accel_z,
    input  logic [THR_W-1:0]  thr,
    input  logic [DUR_W-1:0]  sleep_dur,
    input  logic              feat_en,
    input  logic              irq_route,
    input  logic [RATE_W-1:0] rate_code,
    output logic              sleep_state,
    output logic              sleep_irq,
    output logic              rate_override,
    output logic [RATE_W-1:0] eff_rate
);
    localparam int AXES = 3;

    logic [AXES*DATA_W-1:0] samples;
    logic                   any_over;
    logic                   rate_ok;

    // Pack axes and qualify the nominal rate.
    always_comb begin
        samples = {accel_z, accel_y, accel_x};
        rate_ok = (rate_code <= RATE_W'(MAX_OK));
    end

    ai_quiet_detect #(.DATA_W(DATA_W), .THR_W(THR_W), .AXES(AXES)) u_det (
        .samples  (samples),
        .thr      (thr),
        .any_over (any_over)
    );

    ai_sleep_fsm #(.DUR_W(DUR_W), .BLOCK_LOG2(BLOCK_LOG2)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .feat_en      (feat_en),
        .rate_ok      (rate_ok),
        .sample_valid (sample_valid),
        .any_over     (any_over),
        .sleep_dur    (sleep_dur),
        .sleep        (sleep_state)
    );

    ai_rate_mux #(.RATE_W(RATE_W), .LOW_CODE(LOW_CODE)) u_mux (
        .sleep         (sleep_state),
        .irq_route     (irq_route),
        .rate_code     (rate_code),
        .eff_rate      (eff_rate),
        .rate_override (rate_override),
        .sleep_irq     (sleep_irq)
    );

    AST_OVERRIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_state |-> (eff_rate != rate_code || rate_code == RATE_W'(LOW_CODE))); // R4
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_route |-> !sleep_irq); // R9
endmodule

// File: tb/act_inact_ctrl_test.sv
module act_inact_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] accel_x = '0, accel_y = '0, accel_z = '0;
    logic [5:0]  thr = 6'd2;
    logic [3:0]  sleep_dur = 4'd0;
    logic        feat_en = 1'b1;
    logic        irq_route = 1'b1;
    logic [3:0]  rate_code = 4'd4;
    logic        sleep_state, sleep_irq, rate_override;
    logic [3:0]  eff_rate;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    act_inact_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .accel_x(accel_x), .accel_y(accel_y), .accel_z(accel_z),
        .thr(thr), .sleep_dur(sleep_dur), .feat_en(feat_en),
        .irq_route(irq_route), .rate_code(rate_code),
        .sleep_state(sleep_state), .sleep_irq(sleep_irq),
        .rate_override(rate_override), .eff_rate(eff_rate)
    );

    typedef struct packed {
        logic [5:0]  t;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] z;
        logic        exp_sleep;
    } vec_t;

    // Probe sample applied to a sleeping block; exp_sleep 0 means it must wake (R1).
    localparam vec_t VECS [9] = '{
        '{6'd2,  16'h0400, 16'h0000, 16'h0000, 1'b1},
        '{6'd2,  16'h0401, 16'h0000, 16'h0000, 1'b0},
        '{6'd2,  16'h0000, 16'hFC00, 16'h0000, 1'b1},
        '{6'd2,  16'h0000, 16'h0000, 16'hFBFF, 1'b0},
        '{6'd0,  16'h0001, 16'h0000, 16'h0000, 1'b0},
        '{6'd0,  16'h0000, 16'h0000, 16'h0000, 1'b1},
        '{6'd63, 16'h7FFF, 16'h0000, 16'h0000, 1'b0},
        '{6'd63, 16'h0000, 16'h0000, 16'h8000, 1'b0},
        '{6'd63, 16'h7E00, 16'h8200, 16'h0000, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive n samples on consecutive cycles; returns at a negedge after the last capture.
    task automatic feed(input logic [15:0] x, input logic [15:0] y,
                        input logic [15:0] z, input int n, input logic v = 1'b1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_valid = v; accel_x = x; accel_y = y; accel_z = z;
        end
        @(negedge clk);
        sample_valid = 1'b0; accel_x = '0; accel_y = '0; accel_z = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        check("R11 sleep", sleep_state, 0);
        check("R11 override", rate_override, 0);
        check("R11 eff_rate", eff_rate, 4);

        // Vector table: sleep with 512 zeros, then probe (R1, R5)
        for (int k = 0; k < 9; k++) begin
            do_reset();
            thr = VECS[k].t; sleep_dur = 4'd0;
            feed(16'h0, 16'h0, 16'h0, 512);
            check("R1 setup asleep", sleep_state, 1);
            feed(VECS[k].x, VECS[k].y, VECS[k].z, 1);
            check("R1 probe", sleep_state, VECS[k].exp_sleep);
        end

        // R3 zero duration = 512 samples
        thr = 6'd2; sleep_dur = 4'd0; do_reset();
        feed(16'h0, 16'h0, 16'h0, 511);
        check("R3 at 511", sleep_state, 0);
        feed(16'h0, 16'h0, 16'h0, 1);
        check("R3 at 512", sleep_state, 1);
        // R4 override while asleep
        check("R4 eff_rate low", eff_rate, 1);
        check("R4 override", rate_override, 1);
        // R9 routing
        check("R9 irq routed", sleep_irq, 1);
        irq_route = 1'b0; #1;
        check("R9 irq masked", sleep_irq, 0);
        irq_route = 1'b1;
        // R10 invalid over sample ignored
        feed(16'h7FFF, 16'h0, 16'h0, 3, 1'b0);
        check("R10 invalid ignored", sleep_state, 1);
        // R5 wake
        feed(16'h0, 16'h7000, 16'h0, 1);
        check("R5 woke", sleep_state, 0);
        check("R5 rate restored", eff_rate, 4);
        check("R4 override off", rate_override, 0);

        // R2 duration 2 blocks = 1024
        sleep_dur = 4'd2; do_reset();
        feed(16'h0, 16'h0, 16'h0, 1023);
        check("R2 at 1023", sleep_state, 0);
        feed(16'h0, 16'h0, 16'h0, 1);
        check("R2 at 1024", sleep_state, 1);

        // R7 restart after over sample
        do_reset();
        feed(16'h0, 16'h0, 16'h0, 700);
        feed(16'h0, 16'h0, 16'hF000, 1);
        feed(16'h0, 16'h0, 16'h0, 1023);
        check("R7 not yet", sleep_state, 0);
        feed(16'h0, 16'h0, 16'h0, 1);
        check("R7 full run", sleep_state, 1);

        // R8 disable clears, full run needed after re-enable
        sleep_dur = 4'd0;
        @(negedge clk); feat_en = 1'b0;
        @(negedge clk);
        check("R8 forced active", sleep_state, 0);
        feed(16'h0, 16'h0, 16'h0, 300);
        feat_en = 1'b1;
        feed(16'h0, 16'h0, 16'h0, 511);
        check("R8 count cleared", sleep_state, 0);
        feed(16'h0, 16'h0, 16'h0, 1);
        check("R8 re-entry", sleep_state, 1);

        // R6 rate above 833 Hz keeps active, and wakes a sleeping block
        @(negedge clk); rate_code = 4'd8;
        @(negedge clk);
        check("R6 gate wakes", sleep_state, 0);
        check("R6 eff_rate passthrough", eff_rate, 8);
        feed(16'h0, 16'h0, 16'h0, 600);
        check("R6 stays active", sleep_state, 0);
        rate_code = 4'd7; do_reset();
        feed(16'h0, 16'h0, 16'h0, 512);
        check("R6 833 allowed", sleep_state, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule